// File: doc/BRIEF.md
# Two-Way Address Translation Buffer with Hardware Refill

This block turns 40-bit virtual addresses into 36-bit physical addresses on 16 KB pages. It also checks every access against the rights stored with the page. The low 14 address bits are the page offset and pass through unchanged. The 26-bit virtual page number is split into an 8-bit set index and an 18-bit tag. The tag is searched in the two ways of the indexed set.

A lookup that hits answers in the next cycle. The answer carries the physical address and a permission verdict. A lookup that misses stalls the request port and asks an external page-table walker for the translation. There are two possible outcomes:

- The walker returns an entry. The block writes it into the set and replays the held lookup.
- The walker reports a non-resident page. The block answers with an abort and installs nothing.

When an install overwrites a valid entry, the block reports the evicted page and its dirty state, so that the page can be written back. The requester sees ready held low for the whole miss. The walker sees a steady request until it answers.

Top module: `page_tlb`

## Requirements
- R1: On a completed lookup, `resp_paddr` equals the page's 22-bit physical page number followed by `req_vaddr[13:0]`. The set is selected by `req_vaddr[21:14]` and the tag is `req_vaddr[39:22]`.
- R2: A lookup that hits raises `resp_valid` in the cycle after the clock edge that accepted it, and no walk request is raised.
- R3: On a miss, `walk_req_valid` is high with `walk_req_vpn = req_vaddr[39:14]`, and it stays high with a stable page number until the walker answers. `req_ready` is low for the whole time the miss is pending.
- R4: When the walker answers with `walk_rsp_fault` low, the entry is installed and the lookup is replayed. `resp_valid` rises two cycles after the answer edge. A later access to the same page hits.
- R5: When the walker answers with `walk_rsp_fault` high, `resp_valid` and `resp_abort` rise in the next cycle. Nothing is installed, so the next access to that page misses again.
- R6: The rights field is 3 bits: bit 0 allows read, bit 1 allows write, bit 2 allows user-mode access. A hit that is not allowed completes with `resp_perm_fault` high; this includes the replay after a fill.
- R7: A permitted write hit, including a replayed one, marks the entry dirty. A write that raises a permission fault leaves it clean. The dirty state is visible as `evict_dirty` when the entry is later replaced.
- R8: A fill uses the lowest-numbered invalid way of the set, and in that case no eviction is reported.
- R9: Every completed hit sets the way's reference bit; an install leaves it clear. When both ways are valid, the victim is the lowest-numbered way with a clear reference bit. If every reference bit is set, all of them are cleared and way 0 is replaced.
- R10: `flush` invalidates every entry at one clock edge, and `req_ready` is low in any cycle where `flush` is high.
- R11: After reset, `req_ready` is high and `resp_valid`, `walk_req_valid` and `evict_valid` are low, and every entry is invalid.
- R12: When a fill replaces a valid entry, `evict_valid` pulses for one cycle after the fill edge, with `evict_vpn` set to the replaced page number {tag, set}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted |
| req_vaddr | input | 40 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user-mode access, 0 = privileged |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_paddr | output | 36 | Translated physical address |
| resp_perm_fault | output | 1 | Access violated the page rights |
| resp_abort | output | 1 | Page not resident (walk fault) |
| walk_req_valid | output | 1 | Refill request to the walker |
| walk_req_vpn | output | 26 | Page number to walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_fault | input | 1 | Walker found no resident page |
| walk_rsp_ppn | input | 22 | Returned physical page number |
| walk_rsp_perm | input | 3 | Returned rights field |
| evict_valid | output | 1 | A valid entry was replaced |
| evict_dirty | output | 1 | Replaced entry was dirty |
| evict_vpn | output | 26 | Page number of replaced entry |

## Verification
The hardest state to reach from the ports is a full set in which every reference bit is set, while one resident page is dirty and the other is clean. From that state the aging path clears the bits, and the next fill must then choose the other way.

The stimulus table reaches it by packing successive pages into a single set. The pages are chosen so that each refill's replay sets a reference bit. Some are written with permitted rights and some with forbidden rights. The evicted page number and its dirty flag then expose the reference history and the dirty history at the ports. A flush followed by refills into the same set checks that the lowest invalid way is used first.

// File: rtl/tlb_pkg.sv
// Shared definitions for the translation buffer: controller states and the
// bit positions of the 3-bit rights field. Assumes nothing beyond 1800-2017.
package tlb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_REPLAY = 2'd2
    } tlb_state_e;

    localparam int PERM_W   = 3;
    localparam int PERM_RD  = 0;
    localparam int PERM_WR  = 1;
    localparam int PERM_USR = 2;
endpackage

// File: rtl/tlb_perm.sv
// Rights check: decides whether one access is allowed by a page's rights field.
// Assumes the field layout from tlb_pkg (read, write, user bits).
module tlb_perm
    import tlb_pkg::*;
(
    input  logic [PERM_W-1:0] perm,
    input  logic              is_write,
    input  logic              is_user,
    output logic              allowed
);
    // Access kind must be granted, and user mode needs the user bit.
    always_comb begin
        allowed = (is_write ? perm[PERM_WR] : perm[PERM_RD]) &&
                  (!is_user || perm[PERM_USR]);
    end
endmodule

// File: rtl/tlb_victim.sv
// Replacement choice for one set: the lowest invalid way first, else the lowest
// way whose reference bit is clear, else way 0 with a request to age the set.
// Assumes WAYS >= 2.
module tlb_victim #(
    parameter int WAYS  = 2,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  way_vld,
    input  logic [WAYS-1:0]  way_ref,
    output logic [WAY_W-1:0] victim,
    output logic             age_all
);
    logic found;

    // Priority scan over the two selection rules, then the aging fallback.
    always_comb begin
        victim  = '0;
        found   = 1'b0;
        age_all = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !way_vld[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !way_ref[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            age_all = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_store.sv
// Entry storage: one register array per way holding valid, dirty, reference,
// rights, tag and physical page. Reads of the indexed set are combinational.
// Writes (install, touch, dirty, aging, flush) land on the clock edge.
// Assumes at most one of install/touch applies per way per cycle.
module tlb_store
    import tlb_pkg::*;
#(
    parameter int SET_W = 8,
    parameter int TAG_W = 18,
    parameter int PPN_W = 22,
    parameter int WAYS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [SET_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic              clr_ref,
    input  logic [WAYS-1:0]   inst_w,
    input  logic [WAYS-1:0]   touch_w,
    input  logic [WAYS-1:0]   dirty_w,
    input  logic [PPN_W-1:0]  new_ppn,
    input  logic [PERM_W-1:0] new_perm,
    output logic [WAYS-1:0]   way_vld,
    output logic [WAYS-1:0]   way_ref,
    output logic [WAYS-1:0]   way_dty,
    output logic [WAYS-1:0]   way_hit,
    output logic [TAG_W-1:0]  way_tag [WAYS],
    output logic              hit,
    output logic [PPN_W-1:0]  hit_ppn,
    output logic [PERM_W-1:0] hit_perm
);
    localparam int SETS = 1 << SET_W;

    logic [PPN_W-1:0]  way_ppn  [WAYS];
    logic [PERM_W-1:0] way_perm [WAYS];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic              vld_q  [SETS];
        logic              ref_q  [SETS];
        logic              dty_q  [SETS];
        logic [TAG_W-1:0]  tag_q  [SETS];
        logic [PPN_W-1:0]  ppn_q  [SETS];
        logic [PERM_W-1:0] perm_q [SETS];

        // Status bits: reset/flush clear, install fills, hits touch and dirty.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    vld_q[s] <= 1'b0;
                    ref_q[s] <= 1'b0;
                    dty_q[s] <= 1'b0;
                end
            end else begin
                if (flush) begin
                    for (int s = 0; s < SETS; s++) begin
                        vld_q[s] <= 1'b0;
                    end
                end
                if (clr_ref) begin
                    ref_q[idx] <= 1'b0;
                end
                if (inst_w[g]) begin
                    vld_q[idx] <= 1'b1;
                    ref_q[idx] <= 1'b0;
                    dty_q[idx] <= 1'b0;
                end
                if (touch_w[g]) begin
                    ref_q[idx] <= 1'b1;
                end
                if (dirty_w[g]) begin
                    dty_q[idx] <= 1'b1;
                end
            end
        end

        // Payload fields are written only on install and need no reset.
        always_ff @(posedge clk) begin
            if (inst_w[g]) begin
                tag_q[idx]  <= tag;
                ppn_q[idx]  <= new_ppn;
                perm_q[idx] <= new_perm;
            end
        end

        assign way_vld[g]  = vld_q[idx];
        assign way_ref[g]  = ref_q[idx];
        assign way_dty[g]  = dty_q[idx];
        assign way_tag[g]  = tag_q[idx];
        assign way_ppn[g]  = ppn_q[idx];
        assign way_perm[g] = perm_q[idx];
        assign way_hit[g]  = vld_q[idx] && (tag_q[idx] == tag);
    end

    // Merge the per-way results into a single hit, page and rights.
    always_comb begin
        hit      = 1'b0;
        hit_ppn  = '0;
        hit_perm = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                hit      = 1'b1;
                hit_ppn  = hit_ppn | way_ppn[w];
                hit_perm = hit_perm | way_perm[w];
            end
        end
    end

    // R10: a flush edge without a same-edge install leaves the set empty.
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && inst_w == '0) |=> (way_vld == '0));
endmodule

// File: rtl/page_tlb.sv
// Top of the translation buffer. Accepts a lookup, answers hits one cycle
// later, and on a miss holds the request and asks the walker. A walker answer
// either installs the entry and replays the lookup, or returns an abort.
// Assumes the walker answers only while walk_req_valid is high.
module page_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W  = 40,
    parameter int PA_W  = 36,
    parameter int OFF_W = 14,
    parameter int SET_W = 8,
    parameter int WAYS  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic                   req_write,
    input  logic                   req_user,
    output logic                   resp_valid,
    output logic [PA_W-1:0]        resp_paddr,
    output logic                   resp_perm_fault,
    output logic                   resp_abort,
    output logic                   walk_req_valid,
    output logic [VA_W-OFF_W-1:0]  walk_req_vpn,
    input  logic                   walk_rsp_valid,
    input  logic                   walk_rsp_fault,
    input  logic [PA_W-OFF_W-1:0]  walk_rsp_ppn,
    input  logic [PERM_W-1:0]      walk_rsp_perm,
    output logic                   evict_valid,
    output logic                   evict_dirty,
    output logic [VA_W-OFF_W-1:0]  evict_vpn
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int TAG_W = VPN_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);

    tlb_state_e        st;
    logic [VA_W-1:0]   hold_va;
    logic              hold_wr, hold_usr;
    logic [VA_W-1:0]   lk_va;
    logic              lk_wr, lk_usr;
    logic              accept, do_lookup, complete, fill, wfault;
    logic              lk_hit, perm_ok, age_all, clr_ref;
    logic [PPN_W-1:0]  hit_ppn;
    logic [PERM_W-1:0] hit_perm;
    logic [WAYS-1:0]   way_vld, way_ref, way_dty, way_hit;
    logic [WAYS-1:0]   inst_w, touch_w, dirty_w;
    logic [TAG_W-1:0]  way_tag [WAYS];
    logic [WAY_W-1:0]  victim;

    // Handshake and lookup source: fresh request when idle, held one otherwise.
    always_comb begin
        req_ready      = (st == ST_IDLE) && !flush;
        accept         = req_valid && req_ready;
        lk_va          = (st == ST_IDLE) ? req_vaddr : hold_va;
        lk_wr          = (st == ST_IDLE) ? req_write : hold_wr;
        lk_usr         = (st == ST_IDLE) ? req_user  : hold_usr;
        do_lookup      = accept || (st == ST_REPLAY);
        complete       = do_lookup && lk_hit;
        walk_req_valid = (st == ST_WALK);
        walk_req_vpn   = hold_va[VA_W-1:OFF_W];
        fill           = walk_req_valid && walk_rsp_valid && !walk_rsp_fault;
        wfault         = walk_req_valid && walk_rsp_valid && walk_rsp_fault;
        clr_ref        = fill && age_all;
        inst_w         = fill ? WAYS'(1) << victim : '0;
        touch_w        = complete ? way_hit : '0;
        dirty_w        = (complete && lk_wr && perm_ok) ? way_hit : '0;
    end

    tlb_store #(
        .SET_W (SET_W),
        .TAG_W (TAG_W),
        .PPN_W (PPN_W),
        .WAYS  (WAYS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .idx      (lk_va[OFF_W +: SET_W]),
        .tag      (lk_va[VA_W-1 -: TAG_W]),
        .clr_ref  (clr_ref),
        .inst_w   (inst_w),
        .touch_w  (touch_w),
        .dirty_w  (dirty_w),
        .new_ppn  (walk_rsp_ppn),
        .new_perm (walk_rsp_perm),
        .way_vld  (way_vld),
        .way_ref  (way_ref),
        .way_dty  (way_dty),
        .way_hit  (way_hit),
        .way_tag  (way_tag),
        .hit      (lk_hit),
        .hit_ppn  (hit_ppn),
        .hit_perm (hit_perm)
    );

    tlb_victim #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_victim (
        .way_vld (way_vld),
        .way_ref (way_ref),
        .victim  (victim),
        .age_all (age_all)
    );

    tlb_perm u_perm (
        .perm     (hit_perm),
        .is_write (lk_wr),
        .is_user  (lk_usr),
        .allowed  (perm_ok)
    );

    // Controller: idle -> walk on miss -> replay after fill, or back on fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:   if (accept && !lk_hit) st <= ST_WALK;
                ST_WALK:   if (walk_rsp_valid) st <= walk_rsp_fault ? ST_IDLE : ST_REPLAY;
                ST_REPLAY: st <= lk_hit ? ST_IDLE : ST_WALK;
                default:   st <= ST_IDLE;
            endcase
        end
    end

    // Capture the accepted request so a miss can be walked and replayed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_va  <= '0;
            hold_wr  <= 1'b0;
            hold_usr <= 1'b0;
        end else if (accept) begin
            hold_va  <= req_vaddr;
            hold_wr  <= req_write;
            hold_usr <= req_user;
        end
    end

    // Registered response: completion pulse, address and verdicts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid      <= 1'b0;
            resp_abort      <= 1'b0;
            resp_perm_fault <= 1'b0;
            resp_paddr      <= '0;
        end else begin
            resp_valid      <= complete || wfault;
            resp_abort      <= wfault;
            resp_perm_fault <= complete && !perm_ok;
            if (complete) begin
                resp_paddr <= {hit_ppn, lk_va[OFF_W-1:0]};
            end
        end
    end

    // Eviction report for a fill that overwrites a valid entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evict_valid <= 1'b0;
            evict_dirty <= 1'b0;
            evict_vpn   <= '0;
        end else begin
            evict_valid <= fill && way_vld[victim];
            if (fill) begin
                evict_dirty <= way_dty[victim];
                evict_vpn   <= {way_tag[victim], hold_va[OFF_W +: SET_W]};
            end
        end
    end

    // R2: an accepted lookup that hits completes on the next cycle.
    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |=> (resp_valid && !resp_abort));

    // R3: the requester is stalled while a walk is outstanding.
    a_r3_stall_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !req_ready);

    // R3: the walk page number does not move while the request is held.
    a_r3_walk_vpn_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && $past(walk_req_valid)) |-> $stable(walk_req_vpn));

    // R5: a walker fault becomes an abort response on the next cycle.
    a_r5_abort_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid && walk_rsp_fault) |=> (resp_valid && resp_abort));

    // R4: a successful fill is followed by the replayed completion.
    a_r4_replay_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid && !walk_rsp_fault) |=> ##1 (resp_valid && !resp_abort));

    // R8: a fill into a set with a free way reports no eviction.
    a_r8_free_way_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid && !walk_rsp_fault && !(&way_vld)) |=> !evict_valid);
endmodule

// File: tb/page_tlb_tb.sv
// Bench: walks a stimulus/expectation table, acting as the walker, then runs
// directed reset and flush cases. Sampling is on the falling edge.
module page_tlb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [39:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        resp_valid;
    logic [35:0] resp_paddr;
    logic        resp_perm_fault, resp_abort;
    logic        walk_req_valid;
    logic [25:0] walk_req_vpn;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_fault = 1'b0;
    logic [21:0] walk_rsp_ppn = '0;
    logic [2:0]  walk_rsp_perm = '0;
    logic        evict_valid, evict_dirty;
    logic [25:0] evict_vpn;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    page_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_perm_fault(resp_perm_fault), .resp_abort(resp_abort),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_fault(walk_rsp_fault),
        .walk_rsp_ppn(walk_rsp_ppn), .walk_rsp_perm(walk_rsp_perm),
        .evict_valid(evict_valid), .evict_dirty(evict_dirty), .evict_vpn(evict_vpn)
    );

    // One access: address, kind, walker answer, expected outcome.
    typedef struct packed {
        logic [39:0] va;
        logic        wr;
        logic        usr;
        logic        wf;
        logic [21:0] ppn;
        logic [2:0]  perm;
        logic        miss;
        logic        abort;
        logic        pf;
        logic        ev;
        logic        evd;
        logic [25:0] evvpn;
    } vec_t;

    // Rights bits: [0] read, [1] write, [2] user. Pages share set 5 to force aging.
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{{18'd1,8'd5,14'h123}, 1'b0,1'b0,1'b0, 22'h0AAAA,3'b111, 1'b1,1'b0,1'b0, 1'b0,1'b0,26'h0},
        '{{18'd1,8'd5,14'h3FF}, 1'b0,1'b1,1'b0, 22'h0AAAA,3'b111, 1'b0,1'b0,1'b0, 1'b0,1'b0,26'h0},
        '{{18'd1,8'd5,14'h000}, 1'b1,1'b1,1'b0, 22'h0AAAA,3'b111, 1'b0,1'b0,1'b0, 1'b0,1'b0,26'h0},
        '{{18'd2,8'd5,14'h010}, 1'b0,1'b0,1'b0, 22'h0BBBB,3'b001, 1'b1,1'b0,1'b0, 1'b0,1'b0,26'h0},
        '{{18'd2,8'd5,14'h011}, 1'b1,1'b0,1'b0, 22'h0BBBB,3'b001, 1'b0,1'b0,1'b1, 1'b0,1'b0,26'h0},
        '{{18'd2,8'd5,14'h012}, 1'b0,1'b1,1'b0, 22'h0BBBB,3'b001, 1'b0,1'b0,1'b1, 1'b0,1'b0,26'h0},
        '{{18'd3,8'd5,14'h002}, 1'b0,1'b0,1'b0, 22'h0CCCC,3'b111, 1'b1,1'b0,1'b0, 1'b1,1'b1,{18'd1,8'd5}},
        '{{18'd4,8'd5,14'h004}, 1'b0,1'b0,1'b0, 22'h0DDDD,3'b111, 1'b1,1'b0,1'b0, 1'b1,1'b0,{18'd2,8'd5}},
        '{{18'd5,8'd9,14'h008}, 1'b0,1'b0,1'b1, 22'h0EEEE,3'b111, 1'b1,1'b1,1'b0, 1'b0,1'b0,26'h0},
        '{{18'd5,8'd9,14'h008}, 1'b0,1'b0,1'b0, 22'h0EEEE,3'b111, 1'b1,1'b0,1'b0, 1'b0,1'b0,26'h0},
        '{{18'd3,8'd5,14'h055}, 1'b0,1'b1,1'b0, 22'h0CCCC,3'b111, 1'b0,1'b0,1'b0, 1'b0,1'b0,26'h0},
        '{{18'd6,8'd5,14'h006}, 1'b0,1'b0,1'b0, 22'h0FFFF,3'b111, 1'b1,1'b0,1'b0, 1'b1,1'b0,{18'd3,8'd5}},
        '{{18'd7,8'd200,14'h009}, 1'b1,1'b0,1'b0, 22'h01234,3'b011, 1'b1,1'b0,1'b0, 1'b0,1'b0,26'h0},
        '{{18'd7,8'd200,14'h00A}, 1'b0,1'b1,1'b0, 22'h01234,3'b011, 1'b0,1'b0,1'b1, 1'b0,1'b0,26'h0},
        '{{18'd8,8'd200,14'h001}, 1'b0,1'b0,1'b0, 22'h05678,3'b110, 1'b1,1'b0,1'b1, 1'b0,1'b0,26'h0},
        '{{18'd9,8'd200,14'h002}, 1'b0,1'b0,1'b0, 22'h09999,3'b111, 1'b1,1'b0,1'b0, 1'b1,1'b1,{18'd7,8'd200}}
    };

    // Count a check; report a failure with requirement, actual and expected.
    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Issue one access, play the walker, and check the outcome.
    task automatic run_vec(input vec_t v, input int n);
        int          lat = 1;
        bit          got = 1'b0, saw_walk = 1'b0, saw_ev = 1'b0;
        logic        evd = 1'b0, ab = 1'b0, pf = 1'b0;
        logic [25:0] evv = '0;
        logic [35:0] pa = '0;
        int          exp_lat;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = v.va;
        req_write = v.wr;
        req_user  = v.usr;
        @(negedge clk);
        req_valid = 1'b0;
        while (!got && lat < 20) begin
            if (evict_valid) begin
                saw_ev = 1'b1; evd = evict_dirty; evv = evict_vpn;
            end
            if (resp_valid) begin
                got = 1'b1; ab = resp_abort; pf = resp_perm_fault; pa = resp_paddr;
            end else begin
                if (walk_req_valid && !walk_rsp_valid) begin
                    saw_walk = 1'b1;
                    chk(walk_req_vpn == v.va[39:14], $sformatf("R3 walk vpn v%0d", n), 64'(walk_req_vpn), 64'(v.va[39:14]));
                    chk(req_ready == 1'b0, $sformatf("R3 ready low v%0d", n), 64'(req_ready), 64'(0));
                    walk_rsp_valid = 1'b1;
                    walk_rsp_fault = v.wf;
                    walk_rsp_ppn   = v.ppn;
                    walk_rsp_perm  = v.perm;
                end else begin
                    walk_rsp_valid = 1'b0;
                end
                @(negedge clk);
                lat++;
            end
        end
        walk_rsp_valid = 1'b0;
        exp_lat = !v.miss ? 1 : (v.abort ? 2 : 3);
        chk(got, $sformatf("R2 response seen v%0d", n), 64'(got), 64'(1));
        chk(lat == exp_lat, $sformatf("R2/R4 latency v%0d", n), 64'(lat), 64'(exp_lat));
        chk(saw_walk == v.miss, $sformatf("R3 miss v%0d", n), 64'(saw_walk), 64'(v.miss));
        chk(ab == v.abort, $sformatf("R5 abort v%0d", n), 64'(ab), 64'(v.abort));
        if (!v.abort) begin
            chk(pf == v.pf, $sformatf("R6 perm fault v%0d", n), 64'(pf), 64'(v.pf));
            chk(pa == {v.ppn, v.va[13:0]}, $sformatf("R1 paddr v%0d", n), 64'(pa), 64'({v.ppn, v.va[13:0]}));
        end
        chk(saw_ev == v.ev, $sformatf("R8/R12 evict v%0d", n), 64'(saw_ev), 64'(v.ev));
        if (v.ev) begin
            chk(evd == v.evd, $sformatf("R7 evict dirty v%0d", n), 64'(evd), 64'(v.evd));
            chk(evv == v.evvpn, $sformatf("R9/R12 victim vpn v%0d", n), 64'(evv), 64'(v.evvpn));
        end
    endtask

    initial begin
        vec_t dv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the ports.
        chk(req_ready == 1'b1, "R11 ready after reset", 64'(req_ready), 64'(1));
        chk(resp_valid == 1'b0, "R11 no response after reset", 64'(resp_valid), 64'(0));
        chk(walk_req_valid == 1'b0, "R11 no walk after reset", 64'(walk_req_valid), 64'(0));
        chk(evict_valid == 1'b0, "R11 no evict after reset", 64'(evict_valid), 64'(0));

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], i);
        end

        // R10: flush stalls the port for its cycle and empties every set.
        flush = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R10 ready low during flush", 64'(req_ready), 64'(1'b0));
        @(negedge clk);
        flush = 1'b0;
        // Page F was resident in set 5 way 0; after flush it misses with no eviction.
        dv = '{{18'd6,8'd5,14'h007}, 1'b0,1'b0,1'b0, 22'h0FFFF,3'b111, 1'b1,1'b0,1'b0, 1'b0,1'b0,26'h0};
        run_vec(dv, 100);
        // R8: the second page in the flushed set uses the remaining free way.
        dv = '{{18'd4,8'd5,14'h000}, 1'b0,1'b0,1'b0, 22'h0DDDD,3'b111, 1'b1,1'b0,1'b0, 1'b0,1'b0,26'h0};
        run_vec(dv, 101);
        // R4: both refilled pages now hit.
        dv = '{{18'd6,8'd5,14'h3AB}, 1'b0,1'b0,1'b0, 22'h0FFFF,3'b111, 1'b0,1'b0,1'b0, 1'b0,1'b0,26'h0};
        run_vec(dv, 102);
        dv = '{{18'd4,8'd5,14'h001}, 1'b1,1'b0,1'b0, 22'h0DDDD,3'b111, 1'b0,1'b0,1'b0, 1'b0,1'b0,26'h0};
        run_vec(dv, 103);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule